// File: doc/BRIEF.md
# Down-Counting Timer Bank with APB Register Access

A bank of independent 32-bit down-counters sits behind an APB slave port. Each counter has a reload register, a live count register, a three-bit control register, a read-to-acknowledge register and a masked interrupt status register, laid out in a 0x14-byte slot per timer starting at address 0x00. A shared area above the slots returns the masked and raw interrupt vectors of all timers, a read-to-acknowledge register that clears every pending event at once, and a fixed version word.

A timer advances one step on each clock cycle in which `tick_i` is high. When a step finds the count at zero, the timer flags an event. It then either copies its reload register back in (periodic mode) or rolls over to all ones (free-running mode). The event is latched as a raw status bit and presented as a level interrupt unless masked. Software typically clears the enable bit, writes a reload value and sets enable again. The reload value is copied into the counter on the first clock after enable goes high.

Top module: `tmr_bank`

## Requirements
- R1: Timer n occupies addresses n*0x14 to n*0x14+0x13. Offset 0x00 is the reload register (read/write). Offset 0x04 is the live count. Offset 0x08 is control: bit 0 enable, bit 1 mode, bit 2 mask, reading back with zeros above bit 2. Offset 0x0C is the acknowledge register. Offset 0x10 is the masked status in bit 0.
- R2: While control bit 0 is 0, the count holds its value.
- R3: On the first clock with enable high after it was low, the count takes the reload value. The count then drops by one on each cycle with `tick_i` high, and reading offset 0x04 returns it.
- R4: A cycle with `tick_i` low leaves the count unchanged.
- R5: With control bit 1 = 1 (periodic), a step at count zero raises an event and reloads the reload value.
- R6: With control bit 1 = 0 (free-running), a step at count zero raises an event and sets the count to 0xFFFFFFFF.
- R7: An event sets the timer's raw status bit, which holds until the timer's acknowledge register (offset 0x0C, reads 0) is read. If an event and that read fall in the same cycle, the bit stays set.
- R8: With control bit 2 = 1, `irq_o[n]` and the masked status stay 0 while the raw bit still sets.
- R9: Shared registers: 0xA0 returns the masked vector and 0xA8 the raw vector, timer n at bit n. A read of 0xA4 returns 0 and clears all raw bits. 0xAC returns the `VERSION` parameter.
- R10: Reads of unmapped or misaligned addresses return 0. Writes to read-only or unmapped addresses change nothing. `pready_o` is always 1 and `pslverr_o` always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and counting clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Count enable strobe shared by all timers |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB access phase |
| pwrite_i | input | 1 | APB write when 1 |
| paddr_i | input | 8 | APB byte address |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data |
| pready_o | output | 1 | Always ready |
| pslverr_o | output | 1 | Always 0 |
| irq_o | output | N_TIMERS | Per-timer level interrupt |

## Verification
A counter that mis-steps shows up in the live count read back one access after a burst of ticks. It is measured against a stepping model that replays the same number of ticks from the same reload value. A wrong reload or wrap value first shows one tick after the zero crossing. It then shifts every later count and the event total, so the raw and masked vectors and `irq_o` disagree with the model within the same read sequence. A clear that loses to a simultaneous event, or a stale raw bit after acknowledge, shows on the next read of 0xA8.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int TMR_STRIDE = 'h14;
  localparam int OFF_LOAD   = 'h00;
  localparam int OFF_CUR    = 'h04;
  localparam int OFF_CTRL   = 'h08;
  localparam int OFF_ACK    = 'h0C;
  localparam int OFF_STAT   = 'h10;
  localparam int GLB_STAT   = 'hA0;
  localparam int GLB_ACK    = 'hA4;
  localparam int GLB_RAW    = 'hA8;
  localparam int GLB_VER    = 'hAC;

  localparam int CTRL_EN   = 0;
  localparam int CTRL_MODE = 1;
  localparam int CTRL_MASK = 2;
  localparam int CTRL_W    = 3;

  typedef enum logic [3:0] {
    RS_NONE, RS_LOAD, RS_CUR, RS_CTRL, RS_ACK, RS_STAT,
    RS_G_STAT, RS_G_ACK, RS_G_RAW, RS_G_VER
  } rsel_e;
endpackage

// File: rtl/tmr_apb_decode.sv
module tmr_apb_decode
  import tmr_pkg::*;
#(
  parameter int N_TIMERS = 4,
  parameter int AW       = 8,
  localparam int TW      = (N_TIMERS > 1) ? $clog2(N_TIMERS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                psel_i,
  input  logic                penable_i,
  input  logic                pwrite_i,
  input  logic [AW-1:0]       paddr_i,
  output rsel_e               rsel_o,
  output logic [TW-1:0]       tsel_o,
  output logic [N_TIMERS-1:0] ld_we_o,
  output logic [N_TIMERS-1:0] ctl_we_o,
  output logic [N_TIMERS-1:0] ack_rd_o
);
  logic acc_wr, acc_rd;
  assign acc_wr = psel_i & penable_i & pwrite_i;
  assign acc_rd = psel_i & penable_i & ~pwrite_i;

  always_comb begin
    int a;
    a      = int'(paddr_i);
    rsel_o = RS_NONE;
    tsel_o = '0;
    for (int n = 0; n < N_TIMERS; n++) begin
      if (a >= n * TMR_STRIDE && a < (n + 1) * TMR_STRIDE) begin
        tsel_o = TW'(n);
        case (a - n * TMR_STRIDE)
          OFF_LOAD: rsel_o = RS_LOAD;
          OFF_CUR:  rsel_o = RS_CUR;
          OFF_CTRL: rsel_o = RS_CTRL;
          OFF_ACK:  rsel_o = RS_ACK;
          OFF_STAT: rsel_o = RS_STAT;
          default:  rsel_o = RS_NONE;
        endcase
      end
    end
    case (a)
      GLB_STAT: rsel_o = RS_G_STAT;
      GLB_ACK:  rsel_o = RS_G_ACK;
      GLB_RAW:  rsel_o = RS_G_RAW;
      GLB_VER:  rsel_o = RS_G_VER;
      default: ;
    endcase
  end

  always_comb begin
    for (int n = 0; n < N_TIMERS; n++) begin
      ld_we_o[n]  = acc_wr && rsel_o == RS_LOAD && tsel_o == TW'(n);
      ctl_we_o[n] = acc_wr && rsel_o == RS_CTRL && tsel_o == TW'(n);
      ack_rd_o[n] = acc_rd && ((rsel_o == RS_ACK && tsel_o == TW'(n)) ||
                               rsel_o == RS_G_ACK);
    end
  end

  assert_one_load_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ld_we_o));
  assert_one_ctrl_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ctl_we_o));
  assert_no_write_ack_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwrite_i |-> ack_rd_o == '0);
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              ld_we_i,
  input  logic              ctl_we_i,
  input  logic [CW-1:0]     wdata_i,
  input  logic              ack_rd_i,
  output logic [CW-1:0]     load_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [CW-1:0]     cnt_o,
  output logic              raw_o,
  output logic              irq_o
);
  logic [CW-1:0]     load_q, cnt_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              run_q, raw_q;
  logic              en, periodic, masked, evt;

  assign en       = ctrl_q[CTRL_EN];
  assign periodic = ctrl_q[CTRL_MODE];
  assign masked   = ctrl_q[CTRL_MASK];
  assign evt      = en && run_q && tick_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= '0;
      ctrl_q <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      raw_q  <= 1'b0;
    end else begin
      if (ld_we_i)  load_q <= wdata_i;
      if (ctl_we_i) ctrl_q <= wdata_i[CTRL_W-1:0];
      run_q <= en;
      if (en) begin
        if (!run_q)              cnt_q <= load_q;
        else if (tick_i) begin
          if (cnt_q == '0)       cnt_q <= periodic ? load_q : '1;
          else                   cnt_q <= cnt_q - 1'b1;
        end
      end
      // a new event beats a same-cycle acknowledge
      if (evt)                   raw_q <= 1'b1;
      else if (ack_rd_i)         raw_q <= 1'b0;
    end
  end

  assign load_o = load_q;
  assign ctrl_o = ctrl_q;
  assign cnt_o  = cnt_q;
  assign raw_o  = raw_q;
  assign irq_o  = raw_q & ~masked;

  assert_hold_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> cnt_q == $past(cnt_q));
  assert_start_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en && !run_q |=> cnt_q == $past(load_q));
  assert_no_tick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en && run_q && !tick_i |=> $stable(cnt_q));
  assert_reload_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt && periodic |=> cnt_q == $past(load_q));
  assert_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt && !periodic |=> cnt_q == '1);
  assert_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt |=> raw_q);
  assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_rd_i && !evt |=> !raw_q);
  assert_mask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt && masked && !ctl_we_i |=> raw_q && !irq_o);
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int          N_TIMERS = 4,
  parameter int          AW       = 8,
  parameter int          DW       = 32,
  parameter logic [31:0] VERSION  = 32'h0001_0400,
  localparam int         TW       = (N_TIMERS > 1) ? $clog2(N_TIMERS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                psel_i,
  input  logic                penable_i,
  input  logic                pwrite_i,
  input  logic [AW-1:0]       paddr_i,
  input  logic [DW-1:0]       pwdata_i,
  output logic [DW-1:0]       prdata_o,
  output logic                pready_o,
  output logic                pslverr_o,
  output logic [N_TIMERS-1:0] irq_o
);
  rsel_e                rsel;
  logic [TW-1:0]        tsel;
  logic [N_TIMERS-1:0]  ld_we, ctl_we, ack_rd, raw_v, irq_v;
  logic [DW-1:0]        load_a [N_TIMERS];
  logic [DW-1:0]        cnt_a  [N_TIMERS];
  logic [CTRL_W-1:0]    ctrl_a [N_TIMERS];

  tmr_apb_decode #(.N_TIMERS(N_TIMERS), .AW(AW)) u_dec (
    .clk_i, .rst_ni, .psel_i, .penable_i, .pwrite_i, .paddr_i,
    .rsel_o(rsel), .tsel_o(tsel), .ld_we_o(ld_we), .ctl_we_o(ctl_we),
    .ack_rd_o(ack_rd)
  );

  for (genvar n = 0; n < N_TIMERS; n++) begin : g_tmr
    tmr_channel #(.CW(DW)) u_ch (
      .clk_i, .rst_ni, .tick_i,
      .ld_we_i(ld_we[n]), .ctl_we_i(ctl_we[n]), .wdata_i(pwdata_i),
      .ack_rd_i(ack_rd[n]),
      .load_o(load_a[n]), .ctrl_o(ctrl_a[n]), .cnt_o(cnt_a[n]),
      .raw_o(raw_v[n]), .irq_o(irq_v[n])
    );
  end

  always_comb begin
    case (rsel)
      RS_LOAD:   prdata_o = load_a[tsel];
      RS_CUR:    prdata_o = cnt_a[tsel];
      RS_CTRL:   prdata_o = DW'(ctrl_a[tsel]);
      RS_STAT:   prdata_o = DW'(irq_v[tsel]);
      RS_G_STAT: prdata_o = DW'(irq_v);
      RS_G_RAW:  prdata_o = DW'(raw_v);
      RS_G_VER:  prdata_o = DW'(VERSION);
      default:   prdata_o = '0;
    endcase
  end

  assign pready_o  = 1'b1;
  assign pslverr_o = 1'b0;
  assign irq_o     = irq_v;

  assert_irq_has_raw_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & ~raw_v) == '0);
endmodule

// File: tb/tb_tmr_bank.sv
module tb_tmr_bank;
  localparam int N = 4;
  localparam logic [31:0] VER = 32'h0001_0400;

  logic clk = 0, rst_n = 0, tick = 0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [7:0]  paddr = 0;
  logic [31:0] pwdata = 0, prdata;
  logic pready, pslverr;
  logic [N-1:0] irq;
  int checks = 0, fails = 0;
  bit bus_ok = 1;

  always #4 clk = ~clk;

  tmr_bank #(.N_TIMERS(N), .VERSION(VER)) dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .psel_i(psel),
    .penable_i(penable), .pwrite_i(pwrite), .paddr_i(paddr),
    .pwdata_i(pwdata), .prdata_o(prdata), .pready_o(pready),
    .pslverr_o(pslverr), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    #1 if (!pready || pslverr) bus_ok = 0;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1;
    #1 d = prdata;
    if (!pready || pslverr) bus_ok = 0;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic tick_n(input int k);
    repeat (k) begin @(negedge clk); tick = 1; end
    @(negedge clk); tick = 0;
  endtask

  // stepping model of one timer after its start load
  function automatic void model(input logic [31:0] ld, input int k, input bit per,
                                output logic [31:0] c, output int ev);
    c = ld; ev = 0;
    for (int i = 0; i < k; i++) begin
      if (c == 0) begin c = per ? ld : 32'hFFFF_FFFF; ev++; end
      else c = c - 1;
    end
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d, c;
    int ev;
    int unsigned seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1;

    // reset state
    apb_rd(8'h04, d); chk("R3 reset count", d, 0);
    apb_rd(8'h08, d); chk("R1 reset ctrl", d, 0);
    apb_rd(8'hA8, d); chk("R9 reset raw", d, 0);
    chk("R8 reset irq", 32'(irq), 0);

    // R1 readback
    apb_wr(8'h3C, 32'hDEAD_BEEF); apb_rd(8'h3C, d); chk("R1 load readback", d, 32'hDEAD_BEEF);
    apb_wr(8'h44, 32'hFFFF_FFFE); apb_rd(8'h44, d); chk("R1 ctrl readback", d, 32'h6);
    apb_wr(8'h44, 0);

    // R10 unmapped / read-only
    apb_rd(8'h50, d); chk("R10 unmapped read", d, 0);
    apb_rd(8'h03, d); chk("R10 misaligned read", d, 0);
    apb_wr(8'h04, 32'h1234); apb_rd(8'h04, d); chk("R10 count write ignored", d, 0);
    apb_wr(8'hAC, 0); apb_rd(8'hAC, d); chk("R9 version", d, VER);
    apb_wr(8'hA8, 32'hFF); apb_rd(8'hA8, d); chk("R10 raw write ignored", d, 0);

    // R3/R4/R2 directed on timer 1
    apb_wr(8'h14, 10); apb_wr(8'h1C, 32'h3);
    repeat (5) @(negedge clk);
    apb_rd(8'h18, d); chk("R4 no tick holds, R3 start load", d, 10);
    tick_n(3); apb_rd(8'h18, d); chk("R3 decrement", d, 7);
    apb_wr(8'h1C, 0); tick_n(5); apb_rd(8'h18, d); chk("R2 disabled holds", d, 7);
    apb_wr(8'h1C, 32'h3); apb_rd(8'h18, d); chk("R3 restart from load", d, 10);
    apb_wr(8'h1C, 0);

    // R9 combined clear: timers 0 and 2 free-running from 2
    apb_wr(8'h00, 2); apb_wr(8'h28, 2);
    apb_wr(8'h08, 1); apb_wr(8'h30, 1);
    tick_n(3);
    apb_rd(8'hA8, d); chk("R9 raw vector", d, 32'h5);
    apb_rd(8'hA0, d); chk("R9 masked vector", d, 32'h5);
    apb_rd(8'h04, d); chk("R6 wrap to ones", d, 32'hFFFF_FFFF);
    apb_rd(8'hA4, d); chk("R9 combined ack reads 0", d, 0);
    apb_rd(8'hA8, d); chk("R9 combined ack clears", d, 0);
    apb_wr(8'h08, 0); apb_wr(8'h30, 0);

    // R7 set beats clear: timer 1 periodic from 0, ack read while ticking
    apb_wr(8'h14, 0); apb_wr(8'h1C, 32'h3);
    @(negedge clk); tick = 1; psel = 1; pwrite = 0; paddr = 8'h20;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; tick = 0;
    apb_rd(8'hA8, d); chk("R7 set wins over ack", d, 32'h2);
    apb_rd(8'h20, d); chk("R7 ack reads 0", d, 0);
    apb_rd(8'hA8, d); chk("R7 ack clears", d, 0);
    apb_wr(8'h1C, 0);

    // random runs
    for (int it = 0; it < 40; it++) begin
      int t, k;
      bit per, msk;
      logic [31:0] ld;
      logic [7:0] b;
      t = $urandom_range(0, N - 1);
      ld = $urandom_range(0, 20);
      k = $urandom_range(0, 45);
      per = 1'($urandom_range(0, 1));
      msk = 1'($urandom_range(0, 1));
      b = 8'(t * 20);
      apb_wr(b + 8'h08, 0);
      apb_wr(b, ld);
      apb_wr(b + 8'h08, {29'b0, msk, per, 1'b1});
      tick_n(k);
      model(ld, k, per, c, ev);
      apb_rd(b + 8'h04, d); chk(per ? "R5 periodic count" : "R6 free-run count", d, c);
      apb_rd(8'hA8, d); chk("R7 raw after run", d, (ev > 0) ? (32'h1 << t) : 0);
      apb_rd(8'hA0, d); chk("R8 masked vector", d, (ev > 0 && !msk) ? (32'h1 << t) : 0);
      chk("R8 irq pin", 32'(irq), (ev > 0 && !msk) ? (32'h1 << t) : 0);
      apb_rd(b + 8'h10, d); chk("R8 per-timer status", d, (ev > 0 && !msk) ? 1 : 0);
      apb_rd(b + 8'h0C, d); chk("R7 ack read value", d, 0);
      apb_rd(8'hA8, d); chk("R7 raw cleared", d, 0);
      apb_wr(b + 8'h08, 0);
    end

    chk("R10 pready/pslverr", 32'(bus_ok), 1);
    finish_run();
  end
endmodule